// File: doc/BRIEF.md
# Partitioned Flash Read-Mode Tracker

This block sits on the device side of a 16-bit flash array with 8M words behind a 23-bit word address. The array is split into 32 equal partitions of 256K words. Each partition keeps its own read mode. The four modes are array data, identifier, query table and status. A command write addressed to a partition changes only that partition's mode. On every read request the block looks up the mode of the addressed partition and picks the matching data source. It returns one registered word a cycle later.

Array contents, query table contents and per-partition status bytes come from outside the block on plain input ports. The identifier codes are parameters. Any read that is not an array read completes as a single word, and the wait output stays high for the whole of that response cycle.

Top module: `flash_readmode_tracker`

## Requirements
- R1: After synchronous reset every partition is in array mode, so a read anywhere returns array data with wait_o low.
- R2: A command write (cmd_wr high) sets the mode of partition addr[22:18]. The command byte values are 0xFF for array, 0x90 for identifier, 0x98 for query and 0x70 for status.
- R3: A command write with any other byte value leaves the mode of the addressed partition unchanged.
- R4: A command write never changes the mode of any partition other than the addressed one.
- R5: Each cycle with rd_req high produces exactly one cycle of rd_valid on the next clock edge. rd_valid is low in every other cycle.
- R6: In array mode, rd_data equals the arr_data value present in the request cycle.
- R7: In identifier mode, rd_data depends on the address. Partition offset 0 returns MFR_CODE (default 0x00B3). Offset 1 returns DEV_CODE (default 0x7E21). Offset 2 within any 32K-word block (addr[14:0] == 2) returns {15'b0, lock_bit}. Every other offset returns 0.
- R8: In query mode, rd_data equals the qry_data value present in the request cycle.
- R9: In status mode, rd_data equals {8'h00, stat_bus[8p+7:8p]}, where p is the addressed partition.
- R10: wait_o is high in the response cycle of every identifier, query or status read, and low in all other cycles.
- R11: When a command write and a read hit the same partition in the same cycle, the read uses the mode held before the write. The new mode applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 23 | Word address for both reads and command writes |
| cmd_wr | input | 1 | Command write strobe |
| cmd_byte | input | 8 | Command code (low data byte) |
| rd_req | input | 1 | Read request |
| arr_data | input | 16 | Array word for the current address |
| qry_data | input | 16 | Query table word for the current address |
| lock_bit | input | 1 | Lock status of the addressed block |
| stat_bus | input | 256 | Status byte of each partition, partition p on bits 8p+7:8p |
| rd_data | output | 16 | Registered read result |
| rd_valid | output | 1 | Read result valid |
| wait_o | output | 1 | High during the response of a non-array read |

## Verification
The hardest case to reach is a command write and a read landing on the same partition in the same cycle. The bench drives both strobes together on one shared address and expects the old mode to answer. It then reads again at once to see the new mode take effect. Mode isolation needs a similar setup: neighbouring partitions are first placed in different modes, and the bench then reads all of them so that any leak between table entries shows at the ports.

// File: rtl/flash_rm_pkg.sv
package flash_rm_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_QUERY  = 2'd2,
        MODE_STATUS = 2'd3
    } rmode_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_STATUS = 8'h70;

    typedef struct packed {
        logic   hit;
        rmode_e mode;
    } cmd_dec_t;

    typedef struct packed {
        logic        valid;
        logic        waitf;
        logic [15:0] data;
    } rd_resp_t;

    function automatic cmd_dec_t decode_cmd(input logic [7:0] code);
        cmd_dec_t d;
        d.hit  = 1'b1;
        d.mode = MODE_ARRAY;
        case (code)
            CMD_ARRAY:  d.mode = MODE_ARRAY;
            CMD_IDENT:  d.mode = MODE_IDENT;
            CMD_QUERY:  d.mode = MODE_QUERY;
            CMD_STATUS: d.mode = MODE_STATUS;
            default:    d.hit  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rm_cmd_decode.sv
module rm_cmd_decode
    import flash_rm_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int PART_W = 5
) (
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd_byte,
    output logic              upd_en,
    output logic [PART_W-1:0] upd_part,
    output rmode_e            upd_mode
);
    cmd_dec_t dec;

    always_comb begin
        dec      = decode_cmd(cmd_byte);
        upd_en   = cmd_wr && dec.hit;
        upd_part = addr[ADDR_W-1 -: PART_W];
        upd_mode = dec.mode;
    end
endmodule

// File: rtl/rm_mode_table.sv
module rm_mode_table
    import flash_rm_pkg::*;
#(
    parameter int PART_W = 5,
    localparam int NPART = 1 << PART_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [PART_W-1:0] upd_part,
    input  rmode_e            upd_mode,
    input  logic [PART_W-1:0] rd_part,
    output rmode_e            rd_mode
);
    rmode_e mode_q [NPART];

    for (genvar g = 0; g < NPART; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mode_q[g] <= MODE_ARRAY;
            else if (upd_en && upd_part == PART_W'(g))
                mode_q[g] <= upd_mode;
        end
    end

    assign rd_mode = mode_q[rd_part];
endmodule

// File: rtl/rm_read_mux.sv
module rm_read_mux
    import flash_rm_pkg::*;
#(
    parameter int          ADDR_W   = 23,
    parameter int          PART_W   = 5,
    parameter int          BLK_AW   = 15,
    parameter logic [15:0] MFR_CODE = 16'h00B3,
    parameter logic [15:0] DEV_CODE = 16'h7E21,
    localparam int         NPART    = 1 << PART_W,
    localparam int         OFF_W    = ADDR_W - PART_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   addr,
    input  rmode_e              mode,
    input  logic [15:0]         arr_data,
    input  logic [15:0]         qry_data,
    input  logic                lock_bit,
    input  logic [NPART*8-1:0]  stat_bus,
    output rd_resp_t            resp
);
    logic [PART_W-1:0] part;
    logic [OFF_W-1:0]  offset;
    logic [15:0]       id_word;
    logic [15:0]       sel_word;

    always_comb begin
        part   = addr[ADDR_W-1 -: PART_W];
        offset = addr[OFF_W-1:0];
        if (offset == '0)
            id_word = MFR_CODE;
        else if (offset == OFF_W'(1))
            id_word = DEV_CODE;
        else if (addr[BLK_AW-1:0] == BLK_AW'(2))
            id_word = {15'b0, lock_bit};
        else
            id_word = '0;

        unique case (mode)
            MODE_ARRAY:  sel_word = arr_data;
            MODE_IDENT:  sel_word = id_word;
            MODE_QUERY:  sel_word = qry_data;
            MODE_STATUS: sel_word = {8'h00, stat_bus[part*8 +: 8]};
            default:     sel_word = arr_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp.valid <= rd_req;
            resp.waitf <= rd_req && (mode != MODE_ARRAY);
            resp.data  <= rd_req ? sel_word : resp.data;
        end
    end
endmodule

// File: rtl/flash_readmode_tracker.sv
module flash_readmode_tracker
    import flash_rm_pkg::*;
#(
    parameter int          ADDR_W   = 23,
    parameter int          PART_W   = 5,
    parameter int          BLK_AW   = 15,
    parameter logic [15:0] MFR_CODE = 16'h00B3,
    parameter logic [15:0] DEV_CODE = 16'h7E21,
    localparam int         NPART    = 1 << PART_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_byte,
    input  logic               rd_req,
    input  logic [15:0]        arr_data,
    input  logic [15:0]        qry_data,
    input  logic               lock_bit,
    input  logic [NPART*8-1:0] stat_bus,
    output logic [15:0]        rd_data,
    output logic               rd_valid,
    output logic               wait_o
);
    logic              upd_en;
    logic [PART_W-1:0] upd_part;
    rmode_e            upd_mode;
    rmode_e            rd_mode;
    rd_resp_t          resp;

    rm_cmd_decode #(.ADDR_W(ADDR_W), .PART_W(PART_W)) u_dec (
        .cmd_wr   (cmd_wr),
        .addr     (addr),
        .cmd_byte (cmd_byte),
        .upd_en   (upd_en),
        .upd_part (upd_part),
        .upd_mode (upd_mode)
    );

    rm_mode_table #(.PART_W(PART_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .upd_part (upd_part),
        .upd_mode (upd_mode),
        .rd_part  (addr[ADDR_W-1 -: PART_W]),
        .rd_mode  (rd_mode)
    );

    rm_read_mux #(
        .ADDR_W(ADDR_W), .PART_W(PART_W), .BLK_AW(BLK_AW),
        .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_mux (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .addr     (addr),
        .mode     (rd_mode),
        .arr_data (arr_data),
        .qry_data (qry_data),
        .lock_bit (lock_bit),
        .stat_bus (stat_bus),
        .resp     (resp)
    );

    assign rd_data  = resp.data;
    assign rd_valid = resp.valid;
    assign wait_o   = resp.waitf;
endmodule

// File: rtl/rm_checker.sv
module rm_checker
    import flash_rm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input rmode_e      rd_mode,
    input logic [15:0] arr_data,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        wait_o
);
    // R5
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    // R10
    wait_only_in_resp_chk: assert property (@(posedge clk) disable iff (rst)
        wait_o |-> rd_valid);

    // R10
    wait_on_nonarray_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_mode != MODE_ARRAY) |=> wait_o);

    // R6
    array_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_mode == MODE_ARRAY) |=> (!wait_o && rd_data == $past(arr_data)));
endmodule

bind flash_readmode_tracker rm_checker u_rm_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_mode  (rd_mode),
    .arr_data (arr_data),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .wait_o   (wait_o)
);

// File: tb/test_flash_readmode_tracker.sv
module test_flash_readmode_tracker;
    localparam logic [15:0] MFR = 16'h00B3;
    localparam logic [15:0] DEV = 16'h7E21;

    logic         clk = 1'b0;
    logic         rst;
    logic [22:0]  addr;
    logic         cmd_wr;
    logic [7:0]   cmd_byte;
    logic         rd_req;
    logic [15:0]  arr_data;
    logic [15:0]  qry_data;
    logic         lock_bit;
    logic [255:0] stat_bus;
    logic [15:0]  rd_data;
    logic         rd_valid;
    logic         wait_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    assign arr_data = addr[15:0] ^ 16'h3C3C;
    assign qry_data = {addr[7:0], 8'hA5};

    flash_readmode_tracker i_flash_readmode_tracker (
        .clk(clk), .rst(rst), .addr(addr), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .rd_req(rd_req), .arr_data(arr_data), .qry_data(qry_data),
        .lock_bit(lock_bit), .stat_bus(stat_bus),
        .rd_data(rd_data), .rd_valid(rd_valid), .wait_o(wait_o)
    );

    function automatic logic [22:0] pa(input int p, input int off);
        return {p[4:0], off[17:0]};
    endfunction

    function automatic logic [15:0] arr_of(input logic [22:0] a);
        return a[15:0] ^ 16'h3C3C;
    endfunction

    function automatic logic [15:0] stat_of(input int p);
        return {8'h00, 8'h40 + p[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input int p, input logic [7:0] c);
        @(negedge clk);
        addr = pa(p, 0); cmd_byte = c; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_read(input logic [22:0] a, input logic [15:0] exp_d,
                           input logic exp_w, input string req);
        @(negedge clk);
        addr = a; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid && rd_data == exp_d && wait_o == exp_w, req,
              {rd_valid, wait_o, 14'b0, rd_data}, {1'b1, exp_w, 14'b0, exp_d});
        @(negedge clk);
        check(!rd_valid && !wait_o, "R5/R10 single cycle", {rd_valid, wait_o}, 0);
    endtask

    task automatic t_reset;
        check(!rd_valid && !wait_o, "R1 idle after reset", {rd_valid, wait_o}, 0);
        do_read(pa(0, 16'h1234), arr_of(pa(0, 16'h1234)), 1'b0, "R1 p0 array");
        do_read(pa(17, 7), arr_of(pa(17, 7)), 1'b0, "R1 p17 array");
        do_read(pa(31, 1), arr_of(pa(31, 1)), 1'b0, "R6 p31 array");
    endtask

    task automatic t_modes;
        wr_cmd(3, 8'h90);
        do_read(pa(3, 0), MFR, 1'b1, "R7 manufacturer");
        do_read(pa(3, 1), DEV, 1'b1, "R7 device");
        lock_bit = 1'b1;
        do_read(pa(3, 18'h08002), 16'h0001, 1'b1, "R7 lock set");
        lock_bit = 1'b0;
        do_read(pa(3, 18'h10002), 16'h0000, 1'b1, "R7 lock clear");
        do_read(pa(3, 5), 16'h0000, 1'b1, "R7 other offset");
        wr_cmd(3, 8'h98);
        do_read(pa(3, 9), {8'h09, 8'hA5}, 1'b1, "R8 query");
        wr_cmd(3, 8'h70);
        do_read(pa(3, 4), stat_of(3), 1'b1, "R9 status p3");
        wr_cmd(3, 8'hFF);
        do_read(pa(3, 4), arr_of(pa(3, 4)), 1'b0, "R2 back to array");
    endtask

    task automatic t_indep;
        wr_cmd(5, 8'h90);
        wr_cmd(6, 8'h70);
        do_read(pa(4, 3), arr_of(pa(4, 3)), 1'b0, "R4 p4 untouched");
        do_read(pa(5, 0), MFR, 1'b1, "R4 p5 ident");
        do_read(pa(6, 2), stat_of(6), 1'b1, "R4 p6 status");
        do_read(pa(7, 2), arr_of(pa(7, 2)), 1'b0, "R4 p7 untouched");
    endtask

    task automatic t_badcmd;
        wr_cmd(6, 8'h00);
        wr_cmd(6, 8'h50);
        do_read(pa(6, 2), stat_of(6), 1'b1, "R3 bad codes ignored");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        addr = pa(7, 16'h10); cmd_byte = 8'h70; cmd_wr = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; rd_req = 1'b0;
        check(rd_valid && !wait_o && rd_data == arr_of(pa(7, 16'h10)), "R11 old mode",
              {wait_o, rd_data}, {1'b0, arr_of(pa(7, 16'h10))});
        do_read(pa(7, 16'h10), stat_of(7), 1'b1, "R11 new mode");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        addr = pa(5, 0); rd_req = 1'b1;
        @(negedge clk);
        check(rd_valid && rd_data == MFR, "R5 first of pair", rd_data, MFR);
        addr = pa(5, 1);
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid && wait_o && rd_data == DEV, "R5 second of pair", rd_data, DEV);
        @(negedge clk);
        check(!rd_valid, "R5 pair ends", rd_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; cmd_wr = 1'b0; cmd_byte = '0; rd_req = 1'b0; lock_bit = 1'b0;
        for (int p = 0; p < 32; p++) stat_bus[p*8 +: 8] = 8'h40 + p[7:0];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_modes();
        t_indep();
        t_badcmd();
        t_same_cycle();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule